// File: doc/BRIEF.md
# Command Mailbox Register Interface

This block is a memory-mapped slave that lets a small processor core and the fabric logic around it pass one command at a time. The fabric raises a request by driving `fab_exec` together with an operation code, a locality and a byte count, and fills a shared buffer through its own port. When the request appears, the block captures the descriptor fields and raises a level interrupt toward the processor.

The processor reads the descriptor registers and works on the buffer through a 4 KiB window at `0xF0000000`. It writes any value to the completion register when it is done. That write drops the interrupt, returns the operation code to its idle value of zero, and drives a `complete` pulse of fixed length back to the fabric.

Accesses that hit no register, reads of the write-only completion register, and buffer accesses while no request is pending all return the error word `0xBADFABAC`. Writes in those cases are discarded.

Top module: `cmd_mailbox`

## Requirements
- R1: While reset is held and after it is released, `irq`, `complete` and `rsp_valid` are 0.
- R2: The status word at offset 0x000 returns `fab_exec` in bit 0, `fab_abort` in bit 1 and the current `complete` level in bit 2, with bits 31:3 reading 0.
- R3: The operation register at offset 0x004 holds in bits 3:0 the `fab_op` value sampled in the cycle `fab_exec` rises, with bits 31:4 reading 0. It reads 0 from the cycle after a completion write onward.
- R4: The locality register (offset 0x008, bits 3:0) and the size register (offset 0x00C, bits 15:0) hold `fab_locality` and `fab_size` as sampled in the cycle `fab_exec` rises. Their upper bits read 0.
- R5: A write of any data to offset 0x010 drives `complete` high for exactly 4 cycles, starting the cycle after the write. A further such write while the pulse is running restarts the 4-cycle count.
- R6: A read of offset 0x010 returns 0xBADFABAC.
- R7: A read of any address in the window that matches no register or buffer, and a read of any address outside 0xF0000000–0xF0000FFF, returns 0xBADFABAC. Writes to such addresses change no register.
- R8: While `fab_exec` is 1, offsets 0x800–0xFFF are a 512 x 32-bit RAM. Word index is address bits 10:2, and `req_be` bit n enables byte n (bits 8n+7:8n). The fabric port reads and writes the same words, with its read data one cycle later.
- R9: While `fab_exec` is 0, bus reads of the buffer window return 0xBADFABAC and bus writes to it leave the RAM unchanged.
- R10: `irq` rises the cycle after `fab_exec` rises. It stays 1 until a completion write and is 0 from the cycle after that write.
- R11: `req_ready` is always 1. Every accepted read returns `rsp_valid` = 1 with `rsp_rdata` in the next cycle, and writes return no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for buffer writes |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| fab_exec | input | 1 | Fabric request pending |
| fab_abort | input | 1 | Host abort indication |
| fab_op | input | 4 | Operation code of the request |
| fab_locality | input | 4 | Locality of the request (0xF = none) |
| fab_size | input | 16 | Command length in bytes |
| fab_buf_we | input | 1 | Fabric buffer write enable |
| fab_buf_addr | input | 9 | Fabric buffer word index |
| fab_buf_wdata | input | 32 | Fabric buffer write data |
| fab_buf_rdata | output | 32 | Fabric buffer read data (registered) |
| irq | output | 1 | Level interrupt to the processor |
| complete | output | 1 | Completion pulse to the fabric |

## Verification
The assertions watch the interrupt on every cycle: it is set on a rising request, held until a completion write, and released after one. They also check that a completion write starts the pulse and clears the operation code, and that every read gets a response on the following cycle. Other behaviour can only be seen from the bench's scenarios: the error word on unmapped, write-only and gated addresses, writes that are dropped, byte-enable merging in the buffer, and the exact pulse length when a pulse is restarted. The bench shows these by comparing against its reference model on every clock.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter logic [31:0] BASE         = 32'hF000_0000,
  parameter int          BUF_WORDS    = 512,
  parameter int          PULSE_CYCLES = 4,
  parameter int          SIZE_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              fab_exec,
  input  logic              fab_abort,
  input  logic [3:0]        fab_op,
  input  logic [3:0]        fab_locality,
  input  logic [SIZE_W-1:0] fab_size,
  input  logic              fab_buf_we,
  input  logic [8:0]        fab_buf_addr,
  input  logic [31:0]       fab_buf_wdata,
  output logic [31:0]       fab_buf_rdata,
  output logic              irq,
  output logic              complete
);
  localparam logic [31:0] MAGIC = 32'hBADF_ABAC;
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [31:0] mem [BUF_WORDS];
  logic [CNT_W-1:0] cnt_q;
  logic [3:0] op_q, loc_q;
  logic [SIZE_W-1:0] size_q;
  logic exec_q;
  logic [31:0] reg_val;

  wire [11:0] off = req_addr[11:0];
  wire in_win     = req_addr[31:12] == BASE[31:12];
  wire buf_ok     = in_win && off[11] && fab_exec;
  wire [IDX_W-1:0] idx = off[IDX_W+1:2];
  wire rd_req     = req_valid && !req_write;
  wire wr_compl   = req_valid && req_write && in_win && off == 12'h010;
  wire exec_rise  = fab_exec && !exec_q;

  assign req_ready = 1'b1;
  assign complete  = cnt_q != '0;

  always_comb begin
    reg_val = MAGIC;
    if (in_win)
      case (off)
        12'h000: reg_val = {29'b0, complete, fab_abort, fab_exec};
        12'h004: reg_val = {28'b0, op_q};
        12'h008: reg_val = {28'b0, loc_q};
        12'h00C: reg_val = {{(32-SIZE_W){1'b0}}, size_q};
        default: reg_val = MAGIC;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      exec_q    <= 1'b0;
      irq       <= 1'b0;
      cnt_q     <= '0;
      op_q      <= '0;
      loc_q     <= '0;
      size_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      exec_q    <= fab_exec;
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= buf_ok ? mem[idx] : reg_val;
      if (exec_rise) begin
        irq    <= 1'b1;
        op_q   <= fab_op;
        loc_q  <= fab_locality;
        size_q <= fab_size;
      end else if (wr_compl) begin
        irq  <= 1'b0;
        op_q <= '0;
      end
      if (wr_compl)      cnt_q <= CNT_W'(PULSE_CYCLES);
      else if (complete) cnt_q <= cnt_q - 1'b1;
    end

  always_ff @(posedge clk) begin
    if (req_valid && req_write && buf_ok)
      for (int b = 0; b < 4; b++)
        if (req_be[b]) mem[idx][8*b +: 8] <= req_wdata[8*b +: 8];
    if (fab_buf_we) mem[fab_buf_addr[IDX_W-1:0]] <= fab_buf_wdata;
    fab_buf_rdata <= mem[fab_buf_addr[IDX_W-1:0]];
  end

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_rise |=> irq);
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_compl |=> irq);
  // R10
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_compl && !exec_rise |=> !irq);
  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_compl |=> complete);
  // R3
  op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_compl && !exec_rise |=> op_q == 4'h0);
  // R11
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  // R11
  write_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_valid);
endmodule

// File: tb/test_cmd_mailbox.sv
`timescale 1ns/1ps
module test_cmd_mailbox;
  localparam logic [31:0] MAGIC = 32'hBADF_ABAC;
  localparam logic [31:0] B = 32'hF000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic req_ready, rsp_valid, irq, complete;
  logic [31:0] rsp_rdata, fab_buf_rdata;
  logic fab_exec = 0, fab_abort = 0, fab_buf_we = 0;
  logic [3:0] fab_op = 0, fab_locality = 0;
  logic [15:0] fab_size = 0;
  logic [8:0] fab_buf_addr = 0;
  logic [31:0] fab_buf_wdata = 0;
  logic fab_probe = 0;
  string cur_tag = "R11";

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  cmd_mailbox i_cmd_mailbox (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fab_exec(fab_exec), .fab_abort(fab_abort), .fab_op(fab_op),
    .fab_locality(fab_locality), .fab_size(fab_size), .fab_buf_we(fab_buf_we),
    .fab_buf_addr(fab_buf_addr), .fab_buf_wdata(fab_buf_wdata),
    .fab_buf_rdata(fab_buf_rdata), .irq(irq), .complete(complete));

  // reference model
  logic [31:0] m_mem [int];
  int m_cnt;
  logic m_irq, m_prev_exec, e_rsp_valid, e_fab_chk;
  logic [3:0] m_op, m_loc;
  logic [15:0] m_size;
  logic [31:0] e_rdata, e_fab;
  string e_tag;

  function automatic logic [31:0] model_read(logic [31:0] a);
    if (a[31:12] != B[31:12]) return MAGIC;
    if (a[11]) return fab_exec ? m_mem[int'(a[10:2])] : MAGIC;
    case (a[11:0])
      12'h000: return {29'b0, m_cnt != 0, fab_abort, fab_exec};
      12'h004: return {28'b0, m_op};
      12'h008: return {28'b0, m_loc};
      12'h00C: return {16'b0, m_size};
      default: return MAGIC;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_irq = 0; m_prev_exec = 0; m_op = 0; m_loc = 0; m_size = 0;
      e_rsp_valid = 0; e_fab_chk = 0; e_rdata = 0; e_fab = 0;
    end else begin
      logic cw, rise;
      e_rsp_valid = req_valid && !req_write;
      if (e_rsp_valid) begin e_rdata = model_read(req_addr); e_tag = cur_tag; end
      e_fab_chk = fab_probe;
      if (fab_probe) e_fab = m_mem[int'(fab_buf_addr)];
      cw = req_valid && req_write && req_addr == B + 32'h10;
      rise = fab_exec && !m_prev_exec;
      if (req_valid && req_write && req_addr[31:12] == B[31:12] && req_addr[11] && fab_exec) begin
        logic [31:0] w;
        w = m_mem.exists(int'(req_addr[10:2])) ? m_mem[int'(req_addr[10:2])] : 32'h0;
        for (int b = 0; b < 4; b++) if (req_be[b]) w[8*b +: 8] = req_wdata[8*b +: 8];
        m_mem[int'(req_addr[10:2])] = w;
      end
      if (fab_buf_we) m_mem[int'(fab_buf_addr)] = fab_buf_wdata;
      if (cw) m_cnt = 4; else if (m_cnt > 0) m_cnt--;
      if (rise) begin m_irq = 1; m_op = fab_op; m_loc = fab_locality; m_size = fab_size; end
      else if (cw) begin m_irq = 0; m_op = 0; end
      m_prev_exec = fab_exec;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(irq === m_irq, "R10 irq", {31'b0, irq}, {31'b0, m_irq});
    chk(complete === (m_cnt != 0), "R5 complete", {31'b0, complete}, {31'b0, m_cnt != 0});
    chk(rsp_valid === e_rsp_valid, "R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rsp_valid});
    chk(req_ready === 1'b1, "R11 req_ready", {31'b0, req_ready}, 32'h1);
    if (e_rsp_valid) chk(rsp_rdata === e_rdata, e_tag, rsp_rdata, e_rdata);
    if (e_fab_chk) chk(fab_buf_rdata === e_fab, "R8 fabric port", fab_buf_rdata, e_fab);
  end

  task automatic bus(bit w, logic [31:0] a, logic [31:0] d, logic [3:0] be, string t);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be; cur_tag = t;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic fab_wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); fab_buf_we = 1; fab_buf_addr = a; fab_buf_wdata = d;
    @(negedge clk); fab_buf_we = 0;
  endtask

  task automatic fab_rd(logic [8:0] a);
    @(negedge clk); fab_buf_addr = a; fab_probe = 1;
    @(negedge clk); fab_probe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq === 0 && complete === 0 && rsp_valid === 0, "R1 in reset",
        {29'b0, irq, complete, rsp_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(irq === 0 && complete === 0 && rsp_valid === 0, "R1 after reset",
        {29'b0, irq, complete, rsp_valid}, 32'h0);
    // idle register state
    bus(0, B + 32'h000, 0, 0, "R2 idle status");
    bus(0, B + 32'h004, 0, 0, "R3 idle op");
    bus(0, B + 32'h008, 0, 0, "R4 idle locality");
    bus(0, B + 32'h00C, 0, 0, "R4 idle size");
    // unmapped and outside
    bus(0, B + 32'h014, 0, 0, "R7 unmapped 0x014");
    bus(0, B + 32'h7FC, 0, 0, "R7 unmapped 0x7FC");
    bus(0, B + 32'h003, 0, 0, "R7 unaligned");
    bus(0, 32'h1000_0000, 0, 0, "R7 outside window");
    bus(1, B + 32'h004, 32'h5, 4'hF, "R7 write ro");
    bus(1, B + 32'h020, 32'h5, 4'hF, "R7 write unmapped");
    bus(0, B + 32'h004, 0, 0, "R7 op unchanged");
    // gated buffer
    fab_wr(9'd0, 32'h1122_3344);
    fab_wr(9'd5, 32'hA5A5_0000);
    bus(0, B + 32'h800, 0, 0, "R9 gated read");
    bus(1, B + 32'h800, 32'hFFFF_FFFF, 4'hF, "R9 gated write");
    fab_rd(9'd0);
    // request
    @(negedge clk);
    fab_exec = 1; fab_op = 4'h1; fab_locality = 4'h2; fab_size = 16'd64;
    @(negedge clk);
    fab_op = 4'h3; fab_size = 16'd9;
    repeat (3) @(negedge clk);
    bus(0, B + 32'h000, 0, 0, "R2 exec status");
    bus(0, B + 32'h004, 0, 0, "R3 captured op");
    bus(0, B + 32'h008, 0, 0, "R4 captured locality");
    bus(0, B + 32'h00C, 0, 0, "R4 captured size");
    bus(0, B + 32'h800, 0, 0, "R9 gated write ignored");
    bus(0, B + 32'h814, 0, 0, "R8 buffer read");
    bus(1, B + 32'h800, 32'hDEAD_BEEF, 4'b0101, "R8 byte write");
    bus(0, B + 32'h800, 0, 0, "R8 byte merge");
    bus(1, B + 32'hFFC, 32'hCAFE_F00D, 4'hF, "R8 last word");
    bus(0, B + 32'hFFC, 0, 0, "R8 last word read");
    fab_rd(9'd511);
    fab_rd(9'd0);
    @(negedge clk); fab_abort = 1;
    bus(0, B + 32'h000, 0, 0, "R2 abort bit");
    fab_abort = 0;
    // completion
    bus(1, B + 32'h010, 32'h0, 4'h0, "R5 completion write");
    bus(0, B + 32'h000, 0, 0, "R2 complete bit");
    bus(0, B + 32'h004, 0, 0, "R3 op idle after completion");
    repeat (6) @(negedge clk);
    bus(0, B + 32'h010, 0, 0, "R6 completion read");
    bus(1, B + 32'h010, 32'h1234, 4'hF, "R5 restart first");
    bus(1, B + 32'h010, 32'h0, 4'hF, "R5 restart second");
    repeat (8) @(negedge clk);
    // second request, no locality
    fab_exec = 0;
    repeat (2) @(negedge clk);
    fab_exec = 1; fab_op = 4'h2; fab_locality = 4'hF; fab_size = 16'd4;
    repeat (3) @(negedge clk);
    bus(0, B + 32'h008, 0, 0, "R4 no locality");
    bus(0, B + 32'h004, 0, 0, "R3 second op");
    bus(1, B + 32'h010, 32'h0, 4'h0, "R10 release");
    repeat (6) @(negedge clk);
    fab_exec = 0;
    repeat (2) @(negedge clk);
    bus(0, B + 32'hFFC, 0, 0, "R9 gated after drop");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule